// File: doc/BRIEF.md
# Register-Register ALU with Condition Codes

This block is the purely combinational arithmetic and logic stage of a small 16-bit processor. It serves the register-to-register instruction group. From the 4-bit function code it forms a 16-bit result out of two source operands and the carry flag that is currently held. It also produces the next values of the negative, zero, overflow and carry flags, and it raises one enable for each flag that the operation changes.

A write permission leaves the block alongside the result. This permission is withheld whenever the destination index names the program-counter register. A subtract with that destination therefore works as a compare, and an AND with that destination works as a bit test. Both change the flags and leave every register intact.

The register file, the flag register and the instruction fetch sit around this block. Whatever drives it supplies the operands and the destination index.

Top module: `alu16_cc`

## Requirements
- R1: Function codes 0000, 0001 and 0010 shift opa_i right by one bit. Code 0000 fills bit 15 with 0, code 0001 copies the old bit 15 into bit 15, and code 0010 moves carry_i into bit 15. For all three, the new carry is the old opa_i bit 0.
- R2: For the three shift codes, all four flag enables are 1 and the overflow flag equals the new negative flag XOR the new carry.
- R3: Code 0100 passes opb_i through and code 0111 inverts it. Codes 1000, 1001 and 1010 give opa_i OR, AND and XOR opb_i. For these five codes the overflow flag is 0 with its enable set, and the carry enable is 0.
- R4: Code 0101 gives the two's-complement negation of opb_i and code 0110 gives opb_i plus one. Overflow is set only for an input of 0x8000 (negation) or 0x7FFF (increment). The carry enable is 0.
- R5: Code 1100 gives opa_i + opb_i and code 1110 gives opa_i + opb_i + carry_i. The carry flag is the unsigned carry out of bit 15, overflow is signed two's-complement overflow, and all four enables are 1.
- R6: Code 1101 gives opa_i − opb_i and code 1111 gives opa_i − opb_i − carry_i. The carry flag is 1 exactly when an unsigned borrow occurs, overflow is signed overflow, and all four enables are 1.
- R7: For every defined code, the negative flag equals result bit 15, the zero flag is 1 exactly when the result is 0, and both of their enables are 1.
- R8: wr_en_o is 1 for every defined code unless dst_i equals 7, and then it is 0. The flag values and enables do not depend on dst_i.
- R9: Codes 0011 and 1011 are undefined. For them, all enables, wr_en_o and result_o are 0.
- R10: When a flag's enable is 0, flag_n_o, flag_z_o and flag_v_o are 0 and flag_c_o equals carry_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func_i | input | 4 | Function code (instruction bits 3:0) |
| dst_i | input | 3 | Destination register index |
| opa_i | input | 16 | First source operand |
| opb_i | input | 16 | Second source operand |
| carry_i | input | 1 | Carry flag currently held |
| result_o | output | 16 | Computed result |
| flag_n_o | output | 1 | New negative flag |
| flag_z_o | output | 1 | New zero flag |
| flag_v_o | output | 1 | New overflow flag |
| flag_c_o | output | 1 | New carry flag |
| upd_n_o | output | 1 | Negative flag update enable |
| upd_z_o | output | 1 | Zero flag update enable |
| upd_v_o | output | 1 | Overflow flag update enable |
| upd_c_o | output | 1 | Carry flag update enable |
| wr_en_o | output | 1 | Result write permission |

## Verification
All 16 function codes are run with both carry-in values against an 8×8 grid of corner operands: 0, 1, 0x7FFF, 0x8000, 0xFFFF, two alternating bit patterns and 0x00FF. The 0x7FFF and 0x8000 cases separate signed overflow from unsigned carry. The 0 and 0xFFFF cases exercise borrow and the zero flag. The carry-in sweep separates the rotate from the logical shift, ADC from ADD and SBB from SUB.

The destination index follows the grid, so index 7 is seen under every operation. A further stream of pseudo-random operands covers mid-range sums that no corner value reaches.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
   typedef enum logic [3:0] {
      FN_SHR_LOG = 4'b0000,
      FN_SHR_ARI = 4'b0001,
      FN_SHR_ROT = 4'b0010,
      FN_PASS    = 4'b0100,
      FN_NEGATE  = 4'b0101,
      FN_INCR    = 4'b0110,
      FN_INVERT  = 4'b0111,
      FN_BOR     = 4'b1000,
      FN_BAND    = 4'b1001,
      FN_BXOR    = 4'b1010,
      FN_SUM     = 4'b1100,
      FN_DIFF    = 4'b1101,
      FN_SUMC    = 4'b1110,
      FN_DIFFC   = 4'b1111
   } alu_fn_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } cc_t;
endpackage

// File: rtl/alu16_shift.sv
module alu16_shift #(
   parameter int WIDTH = 16
) (
   input  logic [1:0]       mode_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o
);
   localparam int MSB = WIDTH - 1;

   logic fill;

   always_comb begin
      unique case (mode_i)
         2'b01:   fill = a_i[MSB];
         2'b10:   fill = cin_i;
         default: fill = 1'b0;
      endcase
   end

   assign res_o  = {fill, a_i[MSB:1]};
   assign cout_o = a_i[0];
endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops #(
   parameter int WIDTH = 16
) (
   input  logic [3:0]       func_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] res_o,
   output logic             ovf_o
);
   import alu16_pkg::*;

   localparam logic [WIDTH-1:0] SMIN = {1'b1, {(WIDTH-1){1'b0}}};
   localparam logic [WIDTH-1:0] SMAX = {1'b0, {(WIDTH-1){1'b1}}};
   localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

   always_comb begin
      res_o = '0;
      ovf_o = 1'b0;
      unique case (func_i)
         FN_PASS:   res_o = b_i;
         FN_NEGATE: begin
            res_o = ~b_i + ONE;
            ovf_o = (b_i == SMIN);
         end
         FN_INCR:   begin
            res_o = b_i + ONE;
            ovf_o = (b_i == SMAX);
         end
         FN_INVERT: res_o = ~b_i;
         FN_BOR:    res_o = a_i | b_i;
         FN_BAND:   res_o = a_i & b_i;
         FN_BXOR:   res_o = a_i ^ b_i;
         default:   res_o = '0;
      endcase
   end
endmodule

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   input  logic             usec_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] res_o,
   output logic             c_o,
   output logic             v_o
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] bx;
   logic             c0;
   logic             cout;

   // Subtraction is a + ~b + 1; the borrow flavour replaces the +1 by ~carry.
   assign bx = sub_i ? ~b_i : b_i;
   assign c0 = sub_i ? ~(usec_i & cin_i) : (usec_i & cin_i);

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = c0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign res_o[i]  = a_i[i] ^ bx[i] ^ cy[i];
            assign cy[i+1]   = (a_i[i] & bx[i]) | (cy[i] & (a_i[i] ^ bx[i]));
         end
         assign cout = cy[WIDTH];
         assign v_o  = cy[WIDTH] ^ cy[MSB];
      end else begin : g_flat
         assign {cout, res_o} = {1'b0, a_i} + {1'b0, bx} + {{WIDTH{1'b0}}, c0};
         assign v_o = (a_i[MSB] == bx[MSB]) && (res_o[MSB] != a_i[MSB]);
      end
   endgenerate

   // Carry out of a subtraction is "no borrow"; the flag reports the borrow.
   assign c_o = sub_i ? ~cout : cout;
endmodule

// File: rtl/alu16_cc.sv
module alu16_cc #(
   parameter int WIDTH      = 16,
   parameter int IDX_W      = 3,
   parameter int PC_IDX     = 7,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic [3:0]       func_i,
   input  logic [IDX_W-1:0] dst_i,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] result_o,
   output logic             flag_n_o,
   output logic             flag_z_o,
   output logic             flag_v_o,
   output logic             flag_c_o,
   output logic             upd_n_o,
   output logic             upd_z_o,
   output logic             upd_v_o,
   output logic             upd_c_o,
   output logic             wr_en_o
);
   import alu16_pkg::*;

   localparam int MSB = WIDTH - 1;
   localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu16_cc: WIDTH must be at least 2");
      end
      if (PC_IDX < 0 || PC_IDX >= (1 << IDX_W)) begin : g_bad_pc
         $error("alu16_cc: PC_IDX outside the index range");
      end
   endgenerate

   logic is_shift, is_bit, is_arith, valid;
   logic [WIDTH-1:0] sh_res, bt_res, ad_res, res;
   logic sh_c, bt_v, ad_c, ad_v;
   cc_t  cc;

   assign is_shift = (func_i[3:2] == 2'b00) && (func_i[1:0] != 2'b11);
   assign is_arith = (func_i[3:2] == 2'b11);
   assign is_bit   = (func_i[3:2] == 2'b01) ||
                     ((func_i[3:2] == 2'b10) && (func_i[1:0] != 2'b11));
   assign valid    = is_shift | is_bit | is_arith;

   alu16_shift #(.WIDTH(WIDTH)) shift_i (
      .mode_i (func_i[1:0]),
      .a_i    (opa_i),
      .cin_i  (carry_i),
      .res_o  (sh_res),
      .cout_o (sh_c)
   );

   alu16_bitops #(.WIDTH(WIDTH)) bitops_i (
      .func_i (func_i),
      .a_i    (opa_i),
      .b_i    (opb_i),
      .res_o  (bt_res),
      .ovf_o  (bt_v)
   );

   alu16_addsub #(.WIDTH(WIDTH), .RIPPLE(RIPPLE_ADD)) addsub_i (
      .a_i    (opa_i),
      .b_i    (opb_i),
      .sub_i  (func_i[0]),
      .usec_i (func_i[1]),
      .cin_i  (carry_i),
      .res_o  (ad_res),
      .c_o    (ad_c),
      .v_o    (ad_v)
   );

   always_comb begin
      res  = '0;
      cc   = '0;
      cc.c = carry_i;
      if (is_shift) begin
         res  = sh_res;
         cc.c = sh_c;
         cc.v = sh_res[MSB] ^ sh_c;
      end else if (is_bit) begin
         res  = bt_res;
         cc.v = bt_v;
      end else if (is_arith) begin
         res  = ad_res;
         cc.c = ad_c;
         cc.v = ad_v;
      end
      cc.n = valid & res[MSB];
      cc.z = valid & (res == '0);
   end

   assign result_o = res;
   assign flag_n_o = cc.n;
   assign flag_z_o = cc.z;
   assign flag_v_o = cc.v;
   assign flag_c_o = cc.c;
   assign upd_n_o  = valid;
   assign upd_z_o  = valid;
   assign upd_v_o  = valid;
   assign upd_c_o  = is_shift | is_arith;
   assign wr_en_o  = valid && (dst_i != PC_SEL);
endmodule

// File: rtl/alu16_cc_chk.sv
module alu16_cc_chk #(
   parameter int WIDTH  = 16,
   parameter int IDX_W  = 3,
   parameter int PC_IDX = 7
) (
   input logic [3:0]       func_i,
   input logic [IDX_W-1:0] dst_i,
   input logic [WIDTH-1:0] opa_i,
   input logic             carry_i,
   input logic [WIDTH-1:0] result_o,
   input logic             flag_n_o,
   input logic             flag_z_o,
   input logic             flag_v_o,
   input logic             flag_c_o,
   input logic             upd_n_o,
   input logic             upd_z_o,
   input logic             upd_v_o,
   input logic             upd_c_o,
   input logic             wr_en_o
);
   always_comb begin
      if (!$isunknown({func_i, dst_i, opa_i, carry_i})) begin
         assert_pc_no_write_R8: assert (!(wr_en_o && (dst_i == IDX_W'(PC_IDX))));
         assert_zero_flag_R7: assert (!upd_z_o || (flag_z_o == (result_o == '0)));
         assert_neg_flag_R7: assert (!upd_n_o || (flag_n_o == result_o[WIDTH-1]));
         assert_undef_idle_R9: assert (!((func_i[1:0] == 2'b11) && !func_i[2])
                                       || !(upd_n_o | upd_z_o | upd_v_o | upd_c_o | wr_en_o));
         assert_carry_pass_R10: assert (upd_c_o || (flag_c_o == carry_i));
         assert_shift_carry_R1: assert (!(func_i[3:2] == 2'b00 && upd_c_o) || (flag_c_o == opa_i[0]));
         assert_shift_v_R2: assert (!(func_i[3:2] == 2'b00 && upd_v_o) || (flag_v_o == (flag_n_o ^ flag_c_o)));
         assert_logic_v_clear_R3: assert (!(func_i[3:2] == 2'b10) || (!flag_v_o && !upd_c_o));
      end
   end
endmodule

bind alu16_cc alu16_cc_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W), .PC_IDX(PC_IDX)) chk_i (
   .func_i   (func_i),
   .dst_i    (dst_i),
   .opa_i    (opa_i),
   .carry_i  (carry_i),
   .result_o (result_o),
   .flag_n_o (flag_n_o),
   .flag_z_o (flag_z_o),
   .flag_v_o (flag_v_o),
   .flag_c_o (flag_c_o),
   .upd_n_o  (upd_n_o),
   .upd_z_o  (upd_z_o),
   .upd_v_o  (upd_v_o),
   .upd_c_o  (upd_c_o),
   .wr_en_o  (wr_en_o)
);

// File: tb/alu16_cc_tb_top.sv
module alu16_cc_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  func;
   logic [2:0]  dst;
   logic [15:0] opa, opb;
   logic        cin;
   logic [15:0] result;
   logic        fn, fz, fv, fc, un, uz, uv, uc, we;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   alu16_cc dut_i (
      .func_i (func), .dst_i (dst), .opa_i (opa), .opb_i (opb), .carry_i (cin),
      .result_o (result), .flag_n_o (fn), .flag_z_o (fz), .flag_v_o (fv), .flag_c_o (fc),
      .upd_n_o (un), .upd_z_o (uz), .upd_v_o (uv), .upd_c_o (uc), .wr_en_o (we)
   );

   function automatic logic [15:0] corner(input int k);
      case (k)
         0: corner = 16'h0000;
         1: corner = 16'h0001;
         2: corner = 16'h7FFF;
         3: corner = 16'h8000;
         4: corner = 16'hFFFF;
         5: corner = 16'h5555;
         6: corner = 16'hAAAA;
         default: corner = 16'h00FF;
      endcase
   endfunction

   function automatic string tag_of(input int f, input int d);
      string t;
      case (f)
         0, 1, 2:   t = "R1 R2 R7";
         4, 7:      t = "R3 R7 R10";
         5, 6:      t = "R4 R7 R10";
         8, 9, 10:  t = "R3 R7 R10";
         12, 14:    t = "R5 R7";
         13, 15:    t = "R6 R7";
         default:   t = "R9 R10";
      endcase
      if (d == 7) t = {t, " R8"};
      return t;
   endfunction

   // Returns {result, n, z, v, c, un, uz, uv, uc, we}
   function automatic logic [24:0] model(input int f, input int d, input logic [15:0] a,
                                         input logic [15:0] b, input logic ci);
      int ua = a, ub = b, sa = $signed(a), sb = $signed(b), k = ci;
      int r = 0, s = 0;
      logic n = 0, z = 0, v = 0, c = ci, ok = 1, updc = 0;
      case (f)
         0:  begin r = ua / 2;                             c = ua[0]; updc = 1; end
         1:  begin r = ua / 2 + (ua >= 32768 ? 32768 : 0); c = ua[0]; updc = 1; end
         2:  begin r = ua / 2 + k * 32768;                 c = ua[0]; updc = 1; end
         4:  r = ub;
         5:  begin r = (65536 - ub) % 65536; v = (ub == 32768); end
         6:  begin r = (ub + 1) % 65536;     v = (ub == 32767); end
         7:  r = 65535 - ub;
         8:  r = int'(a | b);
         9:  r = int'(a & b);
         10: r = int'(a ^ b);
         12, 14: begin
            s = ua + ub + ((f == 14) ? k : 0);
            r = s % 65536; c = (s > 65535); updc = 1;
            s = sa + sb + ((f == 14) ? k : 0);
            v = (s > 32767) || (s < -32768);
         end
         13, 15: begin
            s = ua - ub - ((f == 15) ? k : 0);
            r = (s + 65536) % 65536; c = (s < 0); updc = 1;
            s = sa - sb - ((f == 15) ? k : 0);
            v = (s > 32767) || (s < -32768);
         end
         default: ok = 0;
      endcase
      if (ok) begin
         n = (r >= 32768);
         z = (r == 0);
         if (f <= 2) v = n ^ c;
      end
      return {16'(r), n, z, v, c, ok, ok, ok, updc, ok && (d != 7)};
   endfunction

   task automatic apply_check(input int f, input int d, input logic [15:0] a,
                              input logic [15:0] b, input logic ci);
      logic [24:0] exp, act;
      @(posedge clk);
      func = 4'(f); dst = 3'(d); opa = a; opb = b; cin = ci;
      @(negedge clk);
      exp = model(f, d, a, b, ci);
      act = {result, fn, fz, fv, fc, un, uz, uv, uc, we};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s func=%b dst=%0d a=%h b=%h cin=%b actual=%h expected=%h",
                  tag_of(f, d), 4'(f), d, a, b, ci, act, exp);
      end
   endtask

   initial begin
      func = '0; dst = '0; opa = '0; opb = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Reset-state check: all-zero inputs are a logical shift of 0 (R7)
      @(negedge clk);
      checks++;
      if ({result, fn, fz, fv, fc, un, uz, uv, uc, we} !== {16'h0, 9'b010011111}) begin
         fails++;
         $display("FAIL R7 reset state actual=%h expected=%h",
                  {result, fn, fz, fv, fc, un, uz, uv, uc, we}, {16'h0, 9'b010011111});
      end
      for (int f = 0; f < 16; f++)
         for (int ci = 0; ci < 2; ci++)
            for (int ai = 0; ai < 8; ai++)
               for (int bi = 0; bi < 8; bi++)
                  apply_check(f, (ai + bi + f) % 8, corner(ai), corner(bi), 1'(ci));
      begin
         logic [31:0] lfsr = 32'hACE1_1234;
         for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply_check(int'(lfsr[3:0]), int'(lfsr[6:4]), lfsr[22:7],
                        lfsr[31:16] ^ 16'(i * 16'h9E37), lfsr[5]);
         end
      end
      done = 1'b1;
   end

   initial begin
      while (!done && cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
      end
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule